// File: doc/BRIEF.md
# First-Word-Fall-Through FIFO with Retransmit

A single-clock FIFO whose read port always shows the oldest stored word on `rdData`, with `outReady` high whenever that word is valid. A word written into an empty FIFO falls through to the output register by itself. No read command is needed to fetch it. A read enable consumes the shown word, and the next one appears at the same clock edge.

Retransmit lets stored data be read a second time. The request is taken at a clock edge where `rtReq` and `rtMode` are both high. The read pointer then rewinds to the first word written since the most recent reset, and `outReady` drops for three cycles while the rewound head word is fetched. The RAM contents and the write pointer stay as they are.

A request made while the FIFO holds more than D-2 words is refused and flagged on `rtErr`, where D is the usable depth of 2^ADDR_W + 1 words. There are two synchronous resets. A master reset clears everything, including the output word. A partial reset clears the pointers and flags but keeps the last output word.

Top module: `rt_fwft_fifo`

## Requirements
- R1: In the cycle after `masterRst` has been high at a clock edge, `outReady` is 0, `inReady` is 1, `rtErr` is 0 and `rdData` is 0.
- R2: A word written into an empty FIFO shows on `rdData` with `outReady` high after the second clock edge that counts from the write edge. It is not yet visible after the write edge itself. Words come out in the order they were written.
- R3: While `outReady` is high, a clock edge with `rdEn` high moves to the next word. A clock edge with `rdEn` low keeps `outReady` and `rdData` unchanged. A clock edge with `rdEn` high and no word left drops `outReady`.
- R4: The FIFO holds D = 2^ADDR_W + 1 words: 2^ADDR_W in the RAM and one in the output register. `inReady` is low only when the RAM part is full. A write while `inReady` is low is dropped.
- R5: A retransmit is accepted at a clock edge where all of these hold: `rtReq` = 1, `rtMode` = 1, no setup is in progress, and the FIFO holds at most D-2 words. After such an edge, `outReady` is 0 for three cycles and then returns to 1.
- R6: When the setup completes, the read port replays every word written since the most recent reset, in order, starting from the first one. This holds provided at most D-2 words were written since that reset.
- R7: `rdEn` has no effect while setup is in progress. This includes the accepting edge itself.
- R8: Writes made during setup are accepted. They are replayed after the words that were rewound.
- R9: `rtReq` with `rtMode` = 0 has no effect on the flags, the output word or the read order.
- R10: A request that meets R5 except that the FIFO holds more than D-2 words changes nothing. Instead, `rtErr` is 1 for exactly the cycle after that edge.
- R11: After a clock edge with `partialRst` high, `outReady` is 0, `inReady` is 1 and `rdData` keeps its previous value. A later retransmit starts from the first word written after this reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| masterRst | input | 1 | Synchronous full reset, active high |
| partialRst | input | 1 | Synchronous reset that keeps the output word, active high |
| wrData | input | DATA_W | Write data |
| wrEn | input | 1 | Write enable |
| inReady | output | 1 | High when a write will be accepted |
| rdData | output | DATA_W | Head word |
| rdEn | input | 1 | Consume the head word |
| outReady | output | 1 | High when rdData holds a valid word |
| rtReq | input | 1 | Retransmit request |
| rtMode | input | 1 | Retransmit qualifier, sampled together with rtReq |
| rtErr | output | 1 | One-cycle pulse for a refused retransmit request |

## Verification
The properties assume that `rtReq` and `rtMode` are stable around the sampling edge. They also assume that no more than D-2 words are written between a reset and a retransmit, because otherwise the rewound replay would cover overwritten RAM locations.

The stimulus drives every input half a period away from the edges. It performs a master or partial reset before each retransmit scenario. It writes at most D-2 words before a retransmit that is expected to be accepted. Only the refusal case fills the FIFO to D words, and there the request is expected to be rejected.

// File: rtl/rt_fwft_fifo_pkg.sv
package rt_fwft_fifo_pkg;
  typedef struct packed {
    logic push;     // store wrData at the write pointer
    logic load;     // move mem[rdPtr] into the output register
    logic rewind;   // read pointer back to the retransmit base
    logic clrPtr;   // clear both pointers
    logic clrData;  // clear the output word
  } dpStrobe_t;
endpackage

// File: rtl/rt_fwft_fifo_ctrl.sv
module rt_fwft_fifo_ctrl
  import rt_fwft_fifo_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int SETUP_CYC = 3
) (
  input  logic              clk,
  input  logic              masterRst,
  input  logic              partialRst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              rtReq,
  input  logic              rtMode,
  input  logic [ADDR_W:0]   wrPtr,
  output dpStrobe_t         strobe,
  output logic              inReady,
  output logic              outReady,
  output logic              rtErr,
  output logic [ADDR_W:0]   count,
  output logic              setupBusy
);
  localparam int RAM_DEPTH  = 1 << ADDR_W;
  localparam int FWFT_DEPTH = RAM_DEPTH + 1;
  localparam int RT_LIMIT   = FWFT_DEPTH - 2;
  localparam int CNT_W      = ADDR_W + 1;
  localparam int OCC_W      = ADDR_W + 2;
  localparam int PH_W       = $clog2(SETUP_CYC + 1);

  logic [CNT_W-1:0] countQ;
  logic [PH_W-1:0]  phaseQ;
  logic             ovQ;
  logic             errQ;
  logic [OCC_W-1:0] occ;
  logic             anyRst, rtHit, rtOk, push, load, rewind;

  always_comb begin
    anyRst = masterRst || partialRst;
    occ    = {1'b0, countQ} + {{(OCC_W-1){1'b0}}, ovQ};
    rtHit  = rtReq && rtMode && (phaseQ == '0);
    rtOk   = occ <= OCC_W'(RT_LIMIT);
    push   = !anyRst && wrEn && (countQ < CNT_W'(RAM_DEPTH));
    rewind = !anyRst && rtHit && rtOk;
    if (anyRst)
      load = 1'b0;
    else if (phaseQ == PH_W'(1))
      load = countQ != '0;
    else if (phaseQ == '0)
      load = !rewind && (countQ != '0) && (!ovQ || rdEn);
    else
      load = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (anyRst) begin
      countQ <= '0;
      phaseQ <= '0;
      ovQ    <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      errQ <= rtHit && !rtOk;
      if (rewind)
        countQ <= wrPtr + CNT_W'(push);
      else
        countQ <= countQ + CNT_W'(push) - CNT_W'(load);
      if (rewind)
        phaseQ <= PH_W'(SETUP_CYC);
      else if (phaseQ != '0)
        phaseQ <= phaseQ - PH_W'(1);
      if (rewind)
        ovQ <= 1'b0;
      else if (phaseQ > PH_W'(1))
        ovQ <= 1'b0;
      else if (load)
        ovQ <= 1'b1;
      else if (phaseQ == '0 && rdEn)
        ovQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.push    = push;
    strobe.load    = load;
    strobe.rewind  = rewind;
    strobe.clrPtr  = anyRst;
    strobe.clrData = masterRst;
  end

  assign inReady   = countQ < CNT_W'(RAM_DEPTH);
  assign outReady  = ovQ;
  assign rtErr     = errQ;
  assign count     = countQ;
  assign setupBusy = phaseQ != '0;
endmodule

// File: rtl/rt_fwft_fifo_dp.sv
module rt_fwft_fifo_dp
  import rt_fwft_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [ADDR_W:0]   wrPtr,
  output logic [DATA_W-1:0] rdData
);
  localparam int RAM_DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [RAM_DEPTH];
  logic [ADDR_W:0]   wrPtrQ;
  logic [ADDR_W-1:0] rdPtrQ;
  logic [DATA_W-1:0] rdDataQ;

  always_ff @(posedge clk) begin
    if (strobe.push)
      mem[wrPtrQ[ADDR_W-1:0]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strobe.clrPtr) begin
      wrPtrQ <= '0;
      rdPtrQ <= '0;
    end else begin
      if (strobe.push)
        wrPtrQ <= wrPtrQ + 1'b1;
      if (strobe.rewind)
        rdPtrQ <= '0;
      else if (strobe.load)
        rdPtrQ <= rdPtrQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clrData)
      rdDataQ <= '0;
    else if (strobe.load)
      rdDataQ <= mem[rdPtrQ];
  end

  assign wrPtr  = wrPtrQ;
  assign rdData = rdDataQ;
endmodule

// File: rtl/rt_fwft_fifo.sv
module rt_fwft_fifo
  import rt_fwft_fifo_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int SETUP_CYC = 3
) (
  input  logic              clk,
  input  logic              masterRst,
  input  logic              partialRst,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  output logic              inReady,
  output logic [DATA_W-1:0] rdData,
  input  logic              rdEn,
  output logic              outReady,
  input  logic              rtReq,
  input  logic              rtMode,
  output logic              rtErr
);
  dpStrobe_t       strobe;
  logic [ADDR_W:0] wrPtr;
  logic [ADDR_W:0] count;
  logic            setupBusy;

  rt_fwft_fifo_ctrl #(.ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC)) u_ctrl (
    .clk(clk), .masterRst(masterRst), .partialRst(partialRst),
    .wrEn(wrEn), .rdEn(rdEn), .rtReq(rtReq), .rtMode(rtMode),
    .wrPtr(wrPtr), .strobe(strobe), .inReady(inReady),
    .outReady(outReady), .rtErr(rtErr), .count(count),
    .setupBusy(setupBusy)
  );

  rt_fwft_fifo_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .strobe(strobe), .wrData(wrData),
    .wrPtr(wrPtr), .rdData(rdData)
  );
endmodule

// File: rtl/rt_fwft_fifo_chk.sv
module rt_fwft_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              masterRst,
  input logic              partialRst,
  input logic              inReady,
  input logic              outReady,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic              rtReq,
  input logic              rtMode,
  input logic              rtErr,
  input logic [ADDR_W:0]   count,
  input logic              setupBusy
);
  localparam int RAM_DEPTH = 1 << ADDR_W;
  localparam int RT_LIMIT  = RAM_DEPTH - 1;

  logic rst;
  logic rstQ = 1'b1;
  int   occ;
  assign rst = masterRst || partialRst;
  assign occ = int'(count) + int'(outReady);
  always_ff @(posedge clk) rstQ <= rst;

  // R3: a held head word stays put
  a_r3_hold: assert property (@(posedge clk) disable iff (rst || rstQ)
    outReady && !rdEn && !(rtReq && rtMode) |=> outReady && $stable(rdData));

  // R4: the count never exceeds the RAM depth, and a full RAM blocks writes
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst || rstQ)
    !inReady |-> count == (ADDR_W+1)'(RAM_DEPTH));

  // R5: an accepted request keeps outReady low for three cycles
  a_r5_setup_low: assert property (@(posedge clk) disable iff (rst || rstQ)
    rtReq && rtMode && !setupBusy && occ <= RT_LIMIT
    |=> !outReady ##1 !outReady ##1 !outReady);

  // R10: an error pulse follows only a request made on a too-full FIFO
  a_r10_err_cause: assert property (@(posedge clk) disable iff (rst || rstQ)
    rtErr |-> $past(rtReq && rtMode && !setupBusy) && $past(occ) > RT_LIMIT);

  // R10: a refused request leaves the output flag as it was
  a_r10_err_no_effect: assert property (@(posedge clk) disable iff (rst || rstQ)
    rtErr |-> outReady == $past(outReady) || $past(rdEn));
endmodule

bind rt_fwft_fifo rt_fwft_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .masterRst(masterRst), .partialRst(partialRst),
  .inReady(inReady), .outReady(outReady), .rdEn(rdEn), .rdData(rdData),
  .rtReq(rtReq), .rtMode(rtMode), .rtErr(rtErr), .count(count),
  .setupBusy(setupBusy)
);

// File: tb/tb_rt_fwft_fifo.sv
`timescale 1ns/1ps
module tb_rt_fwft_fifo;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int DEPTH  = (1 << ADDR_W) + 1;

  logic clk = 1'b0;
  logic masterRst = 1'b1, partialRst = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic wrEn = 1'b0, rdEn = 1'b0, rtReq = 1'b0, rtMode = 1'b0;
  logic inReady, outReady, rtErr;
  logic [DATA_W-1:0] rdData;
  int vectors = 0, miscompares = 0;

  always #5 clk = ~clk;

  rt_fwft_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .masterRst(masterRst), .partialRst(partialRst),
    .wrData(wrData), .wrEn(wrEn), .inReady(inReady), .rdData(rdData),
    .rdEn(rdEn), .outReady(outReady), .rtReq(rtReq), .rtMode(rtMode),
    .rtErr(rtErr)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doMaster();
    masterRst = 1'b1; step(); masterRst = 1'b0;
  endtask

  task automatic doWrite(input logic [DATA_W-1:0] v);
    wrData = v; wrEn = 1'b1; step(); wrEn = 1'b0;
  endtask

  task automatic doRead(input string tag, input logic [DATA_W-1:0] exp);
    check(tag, {31'd0, outReady}, 32'd1);
    check(tag, {24'd0, rdData}, {24'd0, exp});
    rdEn = 1'b1; step(); rdEn = 1'b0;
  endtask

  // accepted retransmit; rdEn held high during setup (R7); optional write (R8)
  task automatic doRetransmit(input bit wrDuring, input logic [DATA_W-1:0] v);
    rtReq = 1'b1; rtMode = 1'b1; rdEn = 1'b1;
    step();
    rtReq = 1'b0; rtMode = 1'b0;
    check("R5", {31'd0, outReady}, 32'd0);
    check("R10", {31'd0, rtErr}, 32'd0);
    if (wrDuring) begin wrData = v; wrEn = 1'b1; end
    step();
    wrEn = 1'b0;
    check("R7", {31'd0, outReady}, 32'd0);
    step();
    check("R5", {31'd0, outReady}, 32'd0);
    rdEn = 1'b0;
    step();
    check("R5", {31'd0, outReady}, 32'd1);
  endtask

  initial begin
    #2000000;
    miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1;
    step(); step();
    masterRst = 1'b0;
    // R1
    check("R1", {31'd0, outReady}, 32'd0);
    check("R1", {31'd0, inReady}, 32'd1);
    check("R1", {31'd0, rtErr}, 32'd0);
    check("R1", {24'd0, rdData}, 32'd0);

    // sweep: k words written, r read, then retransmit and full replay (R2, R3, R5, R6, R7)
    for (int k = 1; k <= DEPTH - 2; k++) begin
      for (int r = 0; r <= k; r++) begin
        doMaster();
        for (int i = 0; i < k; i++) begin
          doWrite(DATA_W'((k << 4) | i));
          if (i == 0) check("R2", {31'd0, outReady}, 32'd0);
        end
        step();
        check("R2", {31'd0, outReady}, 32'd1);
        check("R3", {31'd0, outReady}, 32'd1);
        for (int i = 0; i < r; i++) doRead("R3", DATA_W'((k << 4) | i));
        check("R3", {31'd0, outReady}, (r == k) ? 32'd0 : 32'd1);
        doRetransmit(1'b0, '0);
        for (int i = 0; i < k; i++) doRead("R6", DATA_W'((k << 4) | i));
        check("R6", {31'd0, outReady}, 32'd0);
      end
    end

    // R8: write during setup is appended
    doMaster();
    for (int i = 0; i < 3; i++) doWrite(DATA_W'(8'hA0 + i));
    step();
    doRead("R8", 8'hA0);
    doRetransmit(1'b1, 8'hA3);
    for (int i = 0; i < 4; i++) doRead("R8", DATA_W'(8'hA0 + i));
    check("R8", {31'd0, outReady}, 32'd0);

    // R9: request without qualifier has no effect
    doMaster();
    for (int i = 0; i < 3; i++) doWrite(DATA_W'(8'hB0 + i));
    step();
    doRead("R9", 8'hB0);
    rtReq = 1'b1; rtMode = 1'b0; step(); rtReq = 1'b0;
    step(); step(); step();
    check("R9", {31'd0, rtErr}, 32'd0);
    doRead("R9", 8'hB1);
    doRead("R9", 8'hB2);
    check("R9", {31'd0, outReady}, 32'd0);

    // R4 and R10: fill to D words, refuse retransmit
    doMaster();
    for (int i = 0; i < DEPTH; i++) doWrite(DATA_W'(8'hC0 + i));
    check("R4", {31'd0, inReady}, 32'd0);
    doWrite(8'hEE);
    rtReq = 1'b1; rtMode = 1'b1; step(); rtReq = 1'b0; rtMode = 1'b0;
    check("R10", {31'd0, rtErr}, 32'd1);
    check("R10", {31'd0, outReady}, 32'd1);
    check("R10", {24'd0, rdData}, 32'hC0);
    step();
    check("R10", {31'd0, rtErr}, 32'd0);
    for (int i = 0; i < DEPTH; i++) doRead("R4", DATA_W'(8'hC0 + i));
    check("R4", {31'd0, outReady}, 32'd0);
    check("R4", {31'd0, inReady}, 32'd1);

    // R11: partial reset keeps the output word, rebases retransmit
    doMaster();
    doWrite(8'hD0); doWrite(8'hD1); step();
    partialRst = 1'b1; step(); partialRst = 1'b0;
    check("R11", {31'd0, outReady}, 32'd0);
    check("R11", {31'd0, inReady}, 32'd1);
    check("R11", {24'd0, rdData}, 32'hD0);
    doWrite(8'h50); doWrite(8'h51); step();
    doRead("R11", 8'h50);
    doRetransmit(1'b0, '0);
    doRead("R11", 8'h50);
    doRead("R11", 8'h51);
    check("R11", {31'd0, outReady}, 32'd0);

    // R1 again after traffic
    doWrite(8'h77); step();
    doMaster();
    check("R1", {31'd0, outReady}, 32'd0);
    check("R1", {24'd0, rdData}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule